// File: doc/BRIEF.md
# DDR Command Decoder with Auto-Precharge Scheduling

This block listens to the command pins of a DDR SDRAM device on every rising clock edge. It turns each pin pattern into a single decoded command strobe. It keeps the mode register and the extended mode register, and it follows four banks through their states: idle, active, waiting for an auto-precharge, and precharging. When a read or a write arrives with the auto-precharge address bit set, the block itself decides the cycle in which that bank's internal precharge begins. It then returns the bank to idle once the precharge time has passed.

A command that breaks the ordering rules is dropped and reported. Examples are a register load while a bank is busy, or any access to a bank whose auto-precharge sequence is still running. Every output is registered, so the result of the command sampled at edge k appears just after edge k. The data path, strobe timing, refresh and the delay-locked loop are out of scope.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: With chip select low, RAS high and CAS low, the command is a read (WE high) or a write (WE low) to the bank on the bank-select pins, with the column taken from A8..A0. A10 high marks the command as auto-precharge. The matching strobe, ap_o, bank_o and col_o appear after the sampling edge. A read or write is accepted only to a bank in the active state.
- R2: An activate (chip select low, RAS low, CAS high, WE high) to an idle bank asserts act_o and moves that bank to the active state, code 01. This restarts the bank's row-active timer.
- R3: A mode register load (RAS, CAS and WE low, bank select 00) with every bank idle asserts mrs_o and copies A11..A0 into mode_o. Burst length comes from mode_o[2:0]: 001 gives 2, 010 gives 4, and every other code gives 8.
- R4: A mode or extended mode register load while any bank is not idle asserts err_o and leaves both registers unchanged.
- R5: An extended mode register load (bank select 01) with every bank idle asserts emrs_o and copies A11..A0 into ext_mode_o. dll_en_o is the inverse of ext_mode_o[0].
- R6: A no-operation (RAS, CAS and WE high) or a deselect (chip select high) asserts no strobe and no error, and changes no bank state.
- R7: A read with auto-precharge puts the bank in the wait state, code 10, from edge r. The bank enters the precharge state, code 11, at edge max(r + BL/2, a + T_RAS), where a is the edge of the activate. It stays there for T_RP cycles and then returns to idle, code 00.
- R8: A write with auto-precharge at edge w follows the same sequence. Its precharge starts at edge max(w + BL/2 + T_WR, a + T_RAS).
- R9: Any command other than a no-operation or deselect that targets a bank in state 10 or 11 asserts err_o and has no effect.
- R10: A precharge command (RAS low, CAS high, WE low) asserts pre_o. With A10 low it returns the selected bank from active to idle, and it has no effect on an idle bank. With A10 high it idles every active bank. If any bank is in state 10 or 11, it is rejected with err_o instead.
- R11: An activate to a bank that is not idle, or a read or write to an idle bank, asserts err_o and has no effect.
- R12: After reset all banks are idle, both registers are zero, and no strobe or error is asserted. err_o is never asserted together with a command strobe, and at most one command strobe is asserted at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address pins |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| mrs_o | output | 1 | Mode register loaded |
| emrs_o | output | 1 | Extended mode register loaded |
| ap_o | output | 1 | Accepted read/write carries auto-precharge |
| bank_o | output | 2 | Bank of the last accepted bank command |
| col_o | output | 9 | Column of the last accepted read/write |
| mode_o | output | 12 | Mode register |
| ext_mode_o | output | 12 | Extended mode register |
| dll_en_o | output | 1 | DLL enable from the extended register |
| bank_state_o | output | 8 | Two bits per bank, bank 0 in bits 1:0 |
| err_o | output | 1 | Command rejected |

## Verification
The auto-precharge timing is tested with a read issued long after its activate and a second read issued one cycle after its activate. These show whether the precharge start follows the half-burst rule or the row-active rule, because each case lets a different one of the two bounds win. A write with auto-precharge issued late separates the added write recovery from the row-active bound. Reads with burst codes 001, 011 and 111 confirm that the wait length follows the mode register. Illegal commands are sent in both the wait and the precharge phases, and also as register loads with banks open, as a precharge-all during a wait, and as accesses to banks in the wrong state. Each one must raise the error and leave the bank states and registers unchanged.

// File: rtl/ddr_dec_pkg.sv
package ddr_dec_pkg;

  typedef enum logic [2:0] {
    C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_MRS, C_EMRS
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'b00,
    B_ACTV = 2'b01,
    B_WAIT = 2'b10,
    B_PRCH = 2'b11
  } bank_st_e;

  // half the burst length, in clock cycles
  function automatic logic [2:0] burst_half(input logic [2:0] code);
    case (code)
      3'b001:  burst_half = 3'd1;
      3'b010:  burst_half = 3'd2;
      default: burst_half = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ddr_cmd_classify.sv
module ddr_cmd_classify
  import ddr_dec_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  output cmd_e            cmd_o
);

  always_comb begin
    cmd_o = C_NONE;
    if (!cs_ni) begin
      case ({ras_ni, cas_ni, we_ni})
        3'b011: cmd_o = C_ACT;
        3'b101: cmd_o = C_RD;
        3'b100: cmd_o = C_WR;
        3'b010: cmd_o = C_PRE;
        3'b000: begin
          if (ba_i == BA_W'(0))      cmd_o = C_MRS;
          else if (ba_i == BA_W'(1)) cmd_o = C_EMRS;
        end
        default: cmd_o = C_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_dec_pkg::*;
#(
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  input  logic [CNT_W-1:0] ap_wait_i,
  output bank_st_e         state_o
);

  localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(T_RAS - 1);

  bank_st_e         state_q;
  logic [CNT_W-1:0] ras_cnt_q, wait_cnt_q, rp_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= B_IDLE;
      ras_cnt_q  <= '0;
      wait_cnt_q <= '0;
      rp_cnt_q   <= '0;
    end else begin
      if (state_q == B_ACTV || state_q == B_WAIT) begin
        if (ras_cnt_q != RAS_LAST) ras_cnt_q <= ras_cnt_q + 1'b1;
      end
      case (state_q)
        B_IDLE: if (act_i) begin
          state_q   <= B_ACTV;
          ras_cnt_q <= '0;
        end
        B_ACTV: begin
          if (pre_i) begin
            state_q <= B_IDLE;
          end else if (ap_i) begin
            state_q    <= B_WAIT;
            wait_cnt_q <= ap_wait_i;
          end
        end
        B_WAIT: begin
          // both the burst/recovery wait and the row-active time must be met
          if (wait_cnt_q <= 1 && ras_cnt_q == RAS_LAST) begin
            state_q  <= B_PRCH;
            rp_cnt_q <= CNT_W'(T_RP);
          end else if (wait_cnt_q != '0) begin
            wait_cnt_q <= wait_cnt_q - 1'b1;
          end
        end
        default: begin
          if (rp_cnt_q <= 1) state_q <= B_IDLE;
          else               rp_cnt_q <= rp_cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign state_o = state_q;

  // R9
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == B_WAIT |=> state_q inside {B_WAIT, B_PRCH});

  // R7
  prch_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == B_PRCH |=> state_q inside {B_PRCH, B_IDLE});

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == B_IDLE && !act_i) |=> state_q == B_IDLE);

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_dec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int BANKS  = 4,
  parameter int AP_BIT = 10,
  parameter int T_RAS  = 6,
  parameter int T_WR   = 2,
  parameter int T_RP   = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  input  logic                  we_ni,
  input  logic [1:0]            ba_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  act_o,
  output logic                  rd_o,
  output logic                  wr_o,
  output logic                  pre_o,
  output logic                  mrs_o,
  output logic                  emrs_o,
  output logic                  ap_o,
  output logic [1:0]            bank_o,
  output logic [COL_W-1:0]      col_o,
  output logic [ADDR_W-1:0]     mode_o,
  output logic [ADDR_W-1:0]     ext_mode_o,
  output logic                  dll_en_o,
  output logic [2*BANKS-1:0]    bank_state_o,
  output logic                  err_o
);

  localparam int CNT_W = $clog2(4 + T_WR + T_RAS + T_RP + 1);

  cmd_e             cmd;
  bank_st_e         st [BANKS];
  bank_st_e         tgt_st;
  logic             all_idle, any_ap, ok, bad, ap_bit;
  logic [BANKS-1:0] act_b, pre_b, ap_b;
  logic [CNT_W-1:0] ap_wait;

  logic act_q, rd_q, wr_q, pre_q, mrs_q, emrs_q, ap_q, err_q;
  logic [1:0]        bank_q;
  logic [COL_W-1:0]  col_q;
  logic [ADDR_W-1:0] mode_q, ext_q;

  ddr_cmd_classify #(.BA_W(2)) i_classify (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .ba_i  (ba_i),
    .cmd_o (cmd)
  );

  assign ap_bit = addr_i[AP_BIT];
  assign tgt_st = st[ba_i];

  always_comb begin
    all_idle = 1'b1;
    any_ap   = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      if (st[b] != B_IDLE) all_idle = 1'b0;
      if (st[b][1])        any_ap   = 1'b1;
    end
    case (cmd)
      C_ACT:         ok = (tgt_st == B_IDLE);
      C_RD, C_WR:    ok = (tgt_st == B_ACTV);
      C_PRE:         ok = ap_bit ? !any_ap : !tgt_st[1];
      C_MRS, C_EMRS: ok = all_idle;
      default:       ok = 1'b0;
    endcase
    bad = (cmd != C_NONE) && !ok;
    for (int b = 0; b < BANKS; b++) begin
      act_b[b] = ok && cmd == C_ACT && ba_i == 2'(b);
      pre_b[b] = ok && cmd == C_PRE && (ap_bit || ba_i == 2'(b));
      ap_b[b]  = ok && (cmd == C_RD || cmd == C_WR) && ap_bit && ba_i == 2'(b);
    end
    ap_wait = CNT_W'(burst_half(mode_q[2:0]))
            + ((cmd == C_WR) ? CNT_W'(T_WR) : CNT_W'(0));
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    ddr_bank_fsm #(.T_RAS(T_RAS), .T_RP(T_RP), .CNT_W(CNT_W)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_b[g]),
      .pre_i    (pre_b[g]),
      .ap_i     (ap_b[g]),
      .ap_wait_i(ap_wait),
      .state_o  (st[g])
    );
    assign bank_state_o[2*g +: 2] = st[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {act_q, rd_q, wr_q, pre_q, mrs_q, emrs_q, ap_q, err_q} <= '0;
      bank_q <= '0;
      col_q  <= '0;
      mode_q <= '0;
      ext_q  <= '0;
    end else begin
      act_q  <= ok && cmd == C_ACT;
      rd_q   <= ok && cmd == C_RD;
      wr_q   <= ok && cmd == C_WR;
      pre_q  <= ok && cmd == C_PRE;
      mrs_q  <= ok && cmd == C_MRS;
      emrs_q <= ok && cmd == C_EMRS;
      ap_q   <= ok && (cmd == C_RD || cmd == C_WR) && ap_bit;
      err_q  <= bad;
      if (ok && cmd inside {C_ACT, C_RD, C_WR, C_PRE}) bank_q <= ba_i;
      if (ok && (cmd == C_RD || cmd == C_WR)) col_q <= addr_i[COL_W-1:0];
      if (ok && cmd == C_MRS)  mode_q <= addr_i;
      if (ok && cmd == C_EMRS) ext_q  <= addr_i;
    end
  end

  assign act_o      = act_q;
  assign rd_o       = rd_q;
  assign wr_o       = wr_q;
  assign pre_o      = pre_q;
  assign mrs_o      = mrs_q;
  assign emrs_o     = emrs_q;
  assign ap_o       = ap_q;
  assign err_o      = err_q;
  assign bank_o     = bank_q;
  assign col_o      = col_q;
  assign mode_o     = mode_q;
  assign ext_mode_o = ext_q;
  assign dll_en_o   = ~ext_q[0];

  // R12
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !(act_q || rd_q || wr_q || pre_q || mrs_q || emrs_q));

  // R12
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_q, rd_q, wr_q, pre_q, mrs_q, emrs_q}));

  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrs_q |-> $stable(mode_q));

  // R5
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emrs_q |-> $stable(ext_q));

  // R1
  ap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_q |-> (rd_q || wr_q));

endmodule

// File: tb/test_ddr_cmd_decoder.sv
module test_ddr_cmd_decoder;

  localparam int CLK_P = 10;

  localparam logic [6:0] F_ACT = 7'b1000000, F_RD  = 7'b0100000,
                         F_WR  = 7'b0010000, F_PRE = 7'b0001000,
                         F_MRS = 7'b0000100, F_EMR = 7'b0000010,
                         F_AP  = 7'b0000001;
  localparam logic [1:0] SI = 2'b00, SA = 2'b01, SW = 2'b10, SP = 2'b11;

  typedef enum {NOP, DES, ACT, RD, WR, PRE, MRS, EMRS} tcmd_e;

  typedef struct {
    logic [6:0]  fl;
    logic        er;
    logic [7:0]  st;
    logic [11:0] m;
    logic [11:0] x;
    logic [1:0]  ba;
    logic [8:0]  col;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic act, rd, wr, pre, mrs, emrs, ap, dll, err;
  logic [1:0]  bank;
  logic [8:0]  col;
  logic [11:0] mode, ext;
  logic [7:0]  bst;

  int checks = 0, errors = 0;
  logic [7:0]  exp_st = '0;
  logic [11:0] em = '0, ex = '0;
  item_t q[$];
  item_t it;

  always #(CLK_P/2) clk = ~clk;

  ddr_cmd_decoder i_ddr_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .ba_i(ba), .addr_i(addr), .act_o(act), .rd_o(rd), .wr_o(wr),
    .pre_o(pre), .mrs_o(mrs), .emrs_o(emrs), .ap_o(ap), .bank_o(bank),
    .col_o(col), .mode_o(mode), .ext_mode_o(ext), .dll_en_o(dll),
    .bank_state_o(bst), .err_o(err)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] want, input string what);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, want);
    end
  endtask

  task automatic set_st(input int b, input logic [1:0] v);
    exp_st[2*b +: 2] = v;
  endtask

  task automatic issue(input tcmd_e c, input logic [1:0] b, input logic [11:0] a,
                       input logic [6:0] fl, input logic er, input string tag);
    item_t e;
    @(negedge clk);
    ba = b; addr = a;
    case (c)
      NOP:       {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      DES:       {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      ACT:       {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      RD:        {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      WR:        {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      PRE:       {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      default:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
    endcase
    e.fl = fl; e.er = er; e.st = exp_st; e.m = em; e.x = ex;
    e.ba = b; e.col = a[8:0]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue((i % 2) ? DES : NOP, 2'd0, 12'h000, 7'd0, 1'b0, tag);
  endtask

  // late read with auto-precharge: wait phase lasts `half` cycles (R7, R3)
  task automatic rda_late(input int b, input int half, input string tag);
    set_st(b, SA); issue(ACT, 2'(b), 12'h000, F_ACT, 1'b0, tag);
    idle(5, tag);
    set_st(b, SW); issue(RD, 2'(b), 12'h4A5, F_RD | F_AP, 1'b0, tag);
    idle(half - 1, tag);
    set_st(b, SP); idle(3, tag);
    set_st(b, SI); idle(1, tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      it = q.pop_front();
      chk({25'd0, act, rd, wr, pre, mrs, emrs, ap}, {25'd0, it.fl}, {it.tag, " strobes"});
      chk({31'd0, err}, {31'd0, it.er}, {it.tag, " err"});
      chk({24'd0, bst}, {24'd0, it.st}, {it.tag, " bank states"});
      chk({20'd0, mode}, {20'd0, it.m}, {it.tag, " mode"});
      chk({20'd0, ext}, {20'd0, it.x}, {it.tag, " ext mode"});
      chk({31'd0, dll}, {31'd0, ~it.x[0]}, {it.tag, " dll_en"});
      if (it.fl[5] || it.fl[4]) begin
        chk({30'd0, bank}, {30'd0, it.ba}, {it.tag, " bank"});
        chk({23'd0, col}, {23'd0, it.col}, {it.tag, " col"});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL R12: watchdog expired, got running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    chk({24'd0, bst}, 32'd0, "R12 reset bank states");
    chk({20'd0, mode, ext}, 32'd0, "R12 reset registers");
    chk({24'd0, act, rd, wr, pre, mrs, emrs, ap, err}, 32'd0, "R12 reset strobes");

    em = 12'h032; issue(MRS, 2'd0, 12'h032, F_MRS, 1'b0, "R3 mode load");
    ex = 12'h001; issue(EMRS, 2'd1, 12'h001, F_EMR, 1'b0, "R5 ext load");

    // late read AP on bank 0, BL=4: precharge at r+2
    set_st(0, SA); issue(ACT, 2'd0, 12'h000, F_ACT, 1'b0, "R2 activate");
    idle(5, "R6 nop/deselect");
    set_st(0, SW); issue(RD, 2'd0, 12'h45A, F_RD | F_AP, 1'b0, "R1 read ap");
    issue(RD, 2'd0, 12'h010, 7'd0, 1'b1, "R9 read in wait");
    set_st(0, SP); issue(NOP, 2'd0, 12'h000, 7'd0, 1'b0, "R7 half-burst bound");
    issue(ACT, 2'd0, 12'h000, 7'd0, 1'b1, "R9 act in precharge");
    idle(1, "R7 precharge");
    set_st(0, SI); idle(1, "R7 back to idle");

    // early read AP on bank 1: precharge held to a+6
    set_st(1, SA); issue(ACT, 2'd1, 12'h000, F_ACT, 1'b0, "R2 activate b1");
    set_st(1, SW); issue(RD, 2'd1, 12'h407, F_RD | F_AP, 1'b0, "R1 early read ap");
    issue(MRS, 2'd0, 12'h003, 7'd0, 1'b1, "R4 mode load busy");
    issue(EMRS, 2'd1, 12'h000, 7'd0, 1'b1, "R4 ext load busy");
    idle(2, "R7 still waiting");
    set_st(1, SP); idle(3, "R7 row-active bound");
    set_st(1, SI); idle(1, "R7 idle after early read");

    // bank 2: plain read/write, then late write AP
    set_st(2, SA); issue(ACT, 2'd2, 12'h000, F_ACT, 1'b0, "R2 activate b2");
    issue(RD, 2'd2, 12'h1FF, F_RD, 1'b0, "R1 plain read");
    issue(WR, 2'd2, 12'h003, F_WR, 1'b0, "R1 plain write");
    set_st(2, SW); issue(WR, 2'd2, 12'h403, F_WR | F_AP, 1'b0, "R8 write ap");
    issue(PRE, 2'd0, 12'h400, 7'd0, 1'b1, "R10 precharge-all during ap");
    idle(2, "R8 recovery");
    set_st(2, SP); idle(3, "R8 precharge start");
    set_st(2, SI); idle(1, "R8 idle");

    // explicit precharge and ordering errors
    set_st(3, SA); issue(ACT, 2'd3, 12'h000, F_ACT, 1'b0, "R2 activate b3");
    set_st(3, SI); issue(PRE, 2'd3, 12'h000, F_PRE, 1'b0, "R10 precharge bank");
    issue(PRE, 2'd2, 12'h000, F_PRE, 1'b0, "R10 precharge idle bank");
    set_st(0, SA); issue(ACT, 2'd0, 12'h000, F_ACT, 1'b0, "R2 activate b0");
    set_st(3, SA); issue(ACT, 2'd3, 12'h000, F_ACT, 1'b0, "R2 activate b3 again");
    issue(ACT, 2'd0, 12'h000, 7'd0, 1'b1, "R11 act on active bank");
    issue(RD, 2'd1, 12'h000, 7'd0, 1'b1, "R11 read idle bank");
    issue(WR, 2'd2, 12'h400, 7'd0, 1'b1, "R11 write idle bank");
    set_st(0, SI); set_st(3, SI);
    issue(PRE, 2'd1, 12'h400, F_PRE, 1'b0, "R10 precharge all");

    // burst length codes
    em = 12'h031; issue(MRS, 2'd0, 12'h031, F_MRS, 1'b0, "R3 burst code 001");
    rda_late(0, 1, "R3 R7 burst 2");
    em = 12'h033; issue(MRS, 2'd0, 12'h033, F_MRS, 1'b0, "R3 burst code 011");
    rda_late(1, 4, "R3 R7 burst 8");
    em = 12'h037; issue(MRS, 2'd0, 12'h037, F_MRS, 1'b0, "R3 burst code 111");
    rda_late(2, 4, "R3 R7 other code");
    ex = 12'h000; issue(EMRS, 2'd1, 12'h000, F_EMR, 1'b0, "R5 dll enable");

    idle(2, "R6 drain");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule